// File: doc/BRIEF.md
# Privilege Mode Sequencer with Preemption Timer

This block decides whether the processor runs with kernel privileges or as an ordinary user task. The answer steers the address decoder elsewhere in the system. Kernel mode is entered only when the CPU fetches an interrupt or break vector. Software interrupts, hardware interrupts and the preemption interrupt all reach the kernel that way.

The way out of kernel mode takes two steps. A write to the task-identifier register only arms the exit. The privilege output drops at the end of the next opcode fetch. As a result, the kernel's return instruction is still fetched with kernel rights, and the task it resumes runs from the instruction after it.

A countdown timer is held at its reload value while the kernel runs. In user mode it counts down, and when it expires it raises a level non-maskable interrupt request. That request stays high until the CPU fetches a vector.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset, `supervisor` is 1 and `nmi_req` is 0.
- R2: At the clock edge that ends a cycle with `vec_pull` high, both the armed flag and `supervisor` become 1.
- R3: At the edge that ends a cycle with `pid_wr` high and `vec_pull` low, the armed flag clears. `supervisor` does not change at that edge.
- R4: At the edge that ends a cycle with `sync_fetch` high and `vec_pull` low, `supervisor` takes the value the armed flag held during that cycle. A `sync_fetch` in the same cycle as `pid_wr` therefore leaves `supervisor` at 1. Without a later fetch, `supervisor` stays 1 after a `pid_wr`, however many cycles pass.
- R5: A fetch while the armed flag is still set, meaning no task-identifier write since the last vector fetch, keeps `supervisor` at 1.
- R6: If `vec_pull` and `pid_wr` are high in the same cycle, the vector fetch wins: both flags are 1 afterwards, and a later fetch leaves `supervisor` at 1.
- R7: While `supervisor` is 1, the timer is held at `RELOAD` and `nmi_req` is 0.
- R8: With no vector fetch in between, `nmi_req` is first 1 after the `RELOAD+1`-th clock edge that follows the edge at which `supervisor` fell.
- R9: Once `nmi_req` is 1, it stays 1 until the edge that ends a cycle with `vec_pull` high. At that edge it becomes 0.
- R10: A vector fetch in user mode before the timer expires reloads the timer. The next user period again lasts the full `RELOAD+1` cycles before `nmi_req` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| vec_pull | input | 1 | High during a cycle in which the CPU reads an interrupt or break vector |
| sync_fetch | input | 1 | High during a cycle in which the CPU fetches an opcode |
| pid_wr | input | 1 | High during a cycle that writes the task-identifier register |
| supervisor | output | 1 | 1 = kernel privileges; drives the address decoder |
| nmi_req | output | 1 | Level non-maskable interrupt request raised when the preemption timer expires |

## Verification
Three collisions can fall in a single cycle:
- A vector fetch can coincide with a task-identifier write. The bench drives both strobes together and then issues a fetch. `supervisor` must stay 1.
- A task-identifier write can coincide with an opcode fetch. The deferred copy must see the old armed value, so `supervisor` stays 1 until a second fetch clears it.
- The timer's expiry can meet a vector fetch. Expiry raises `nmi_req` and the vector fetch clears it. The bench sweeps the gap before the vector fetch across the timer boundary and compares every cycle against an arithmetic count of `RELOAD+1`.

// File: rtl/priv_mode_pkg.sv
package priv_mode_pkg;
  // Two-stage privilege state: armed is cleared by a task-id write,
  // active is the effective flag copied from armed on an opcode fetch.
  typedef struct packed {
    logic armed;
    logic active;
  } mode_flags_t;

  localparam mode_flags_t FLAGS_KERNEL = '{armed: 1'b1, active: 1'b1};
endpackage

// File: rtl/priv_rst_sync.sv
module priv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb shift_d = 1'b1;
    end else begin : g_chain
      always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign rst_sync_no = shift_q[STAGES-1];
endmodule

// File: rtl/priv_mode_flags.sv
module priv_mode_flags
  import priv_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        vec_pull_i,
  input  logic        sync_i,
  input  logic        pid_wr_i,
  output mode_flags_t flags_o
);
  mode_flags_t flags_q;
  mode_flags_t flags_d;
  logic        flags_en;

  always_comb begin
    flags_d = flags_q;
    if (vec_pull_i) begin
      flags_d = FLAGS_KERNEL;           // vector fetch wins over everything
    end else begin
      if (pid_wr_i) flags_d.armed  = 1'b0;
      if (sync_i)   flags_d.active = flags_q.armed; // old armed value
    end
  end

  assign flags_en = vec_pull_i | pid_wr_i | sync_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= FLAGS_KERNEL;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/priv_preempt_timer.sv
module priv_preempt_timer #(
  parameter int CNT_W  = 16,
  parameter int RELOAD = 20000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic ack_i,
  output logic nmi_o
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(RELOAD);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             expired;
  logic             nmi_q, nmi_d;

  assign expired = (cnt_q == '0) & ~hold_i;

  always_comb begin
    cnt_en = hold_i | (cnt_q != '0);
    cnt_d  = hold_i ? LOAD_VAL : cnt_q - 1'b1;
  end

  always_comb begin
    nmi_d = nmi_q;
    if (ack_i)        nmi_d = 1'b0;
    else if (expired) nmi_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= LOAD_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) nmi_q <= 1'b0;
    else         nmi_q <= nmi_d;
  end

  assign nmi_o = nmi_q;
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
  import priv_mode_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RELOAD     = 20000,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vec_pull,
  input  logic sync_fetch,
  input  logic pid_wr,
  output logic supervisor,
  output logic nmi_req
);
  logic        rst_sync_n;
  mode_flags_t flags;
  logic        armed_flag;

  priv_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  priv_mode_flags i_flags (
    .clk        (clk),
    .rst_ni     (rst_sync_n),
    .vec_pull_i (vec_pull),
    .sync_i     (sync_fetch),
    .pid_wr_i   (pid_wr),
    .flags_o    (flags)
  );

  assign armed_flag = flags.armed;
  assign supervisor = flags.active;

  priv_preempt_timer #(.CNT_W(CNT_W), .RELOAD(RELOAD)) i_timer (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .hold_i (flags.active),
    .ack_i  (vec_pull),
    .nmi_o  (nmi_req)
  );
endmodule

// File: rtl/priv_mode_ctrl_chk.sv
module priv_mode_ctrl_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic vec_pull,
  input logic sync_fetch,
  input logic pid_wr,
  input logic armed_flag,
  input logic supervisor,
  input logic nmi_req
);
  p_vec_enter_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_pull |=> (supervisor && armed_flag));

  p_pid_disarm_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pid_wr && !vec_pull && !sync_fetch) |=> (!armed_flag && $stable(supervisor)));

  p_exit_on_fetch_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(supervisor) |-> ($past(sync_fetch) && !$past(armed_flag)));

  p_tie_vec_wins_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (vec_pull && pid_wr) |=> (armed_flag && supervisor));

  p_no_nmi_kernel_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    supervisor |-> !nmi_req);

  p_nmi_level_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (nmi_req && !vec_pull) |=> nmi_req);

  p_nmi_ack_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_pull |=> !nmi_req);
endmodule

bind priv_mode_ctrl priv_mode_ctrl_chk i_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .vec_pull   (vec_pull),
  .sync_fetch (sync_fetch),
  .pid_wr     (pid_wr),
  .armed_flag (armed_flag),
  .supervisor (supervisor),
  .nmi_req    (nmi_req)
);

// File: tb/test_priv_mode_ctrl.sv
`timescale 1ns/1ps
module test_priv_mode_ctrl;
  localparam int RL = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic vec_pull, sync_fetch, pid_wr;
  logic supervisor, nmi_req;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 0;

  always #2 clk = ~clk;

  priv_mode_ctrl #(.CNT_W(4), .RELOAD(RL)) i_priv_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .vec_pull(vec_pull), .sync_fetch(sync_fetch),
    .pid_wr(pid_wr), .supervisor(supervisor), .nmi_req(nmi_req)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at the falling edge, sample at the next falling edge
  task automatic cyc(input logic v, input logic s, input logic p);
    vec_pull = v; sync_fetch = s; pid_wr = p;
    @(posedge clk);
    @(negedge clk);
    vec_pull = 1'b0; sync_fetch = 1'b0; pid_wr = 1'b0;
  endtask

  // vector, task-id write, fetch: leaves user mode with supervisor just fallen
  task automatic enter_user();
    cyc(1, 0, 0);
    cyc(0, 0, 1);
    cyc(0, 1, 0);
  endtask

  initial begin
    rst_n = 1'b0; vec_pull = 1'b0; sync_fetch = 1'b0; pid_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 supervisor after reset", supervisor, 1'b1);
    chk("R1 nmi_req after reset", nmi_req, 1'b0);

    // R5: fetches with no task-id write keep kernel mode
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 0);
      chk("R5 fetch while armed", supervisor, 1'b1);
    end

    // R3/R4: sweep the gap between task-id write and the next fetch
    for (int gap = 0; gap < 7; gap++) begin
      cyc(1, 0, 0);
      chk("R2 vector enters kernel", supervisor, 1'b1);
      cyc(0, 0, 1);
      chk("R3 write leaves supervisor", supervisor, 1'b1);
      for (int k = 0; k < gap; k++) begin
        cyc(0, 0, 0);
        chk("R4 no fetch keeps supervisor", supervisor, 1'b1);
      end
      cyc(0, 1, 0);
      chk("R4 fetch after write exits", supervisor, 1'b0);
      chk("R8 nmi low at exit", nmi_req, 1'b0);
    end

    // R4: write and fetch in the same cycle copy the old armed value
    cyc(1, 0, 0);
    cyc(0, 1, 1);
    chk("R4 same-cycle write+fetch stays", supervisor, 1'b1);
    cyc(0, 1, 0);
    chk("R4 second fetch exits", supervisor, 1'b0);

    // R6: vector and write together, vector wins
    cyc(1, 0, 1);
    chk("R6 tie supervisor", supervisor, 1'b1);
    cyc(0, 1, 0);
    chk("R6 tie then fetch stays", supervisor, 1'b1);

    // R7: kernel mode long run, timer held
    for (int k = 0; k < 4 * RL; k++) begin
      cyc(0, 0, 0);
      chk("R7 no nmi in kernel", nmi_req, 1'b0);
    end

    // R8/R9: count after exit, then acknowledge at different delays
    for (int extra = 0; extra < 4; extra++) begin
      enter_user();
      for (int k = 1; k <= RL + 1 + extra; k++) begin
        cyc(0, 0, 0);
        chk("R8 nmi timing", nmi_req, logic'(k >= RL + 1));
      end
      cyc(0, 1, 0);
      chk("R9 nmi holds through fetch", nmi_req, 1'b1);
      cyc(1, 0, 0);
      chk("R9 vector clears nmi", nmi_req, 1'b0);
      chk("R2 vector in user mode", supervisor, 1'b1);
    end

    // R10: early vector reloads the timer
    for (int early = 1; early <= RL; early++) begin
      enter_user();
      repeat (early) cyc(0, 0, 0);
      chk("R10 not yet expired", nmi_req, 1'b0);
      enter_user();
      for (int k = 1; k <= RL + 1; k++) begin
        cyc(0, 0, 0);
        chk("R10 full period after reload", nmi_req, logic'(k == RL + 1));
      end
      cyc(1, 0, 0);
    end

    // R1: reset in user mode with a pending request
    enter_user();
    repeat (RL + 2) cyc(0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset restores supervisor", supervisor, 1'b1);
    chk("R1 reset clears nmi", nmi_req, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule